// File: doc/BRIEF.md
# Staged Filter Coefficient Upload Controller

This block sits between a byte-wide host register port and a 64-entry store of 24-bit signed fixed-point filter coefficients. Each coefficient covers the range -1 to just under +1 and appears to the host as three bytes, most significant first. The host fills a 15-byte staging bank, sets a coefficient address, then writes a command. The command does one of four things. It commits one coefficient to the store, or it commits a five-coefficient biquad set. It can also fetch one coefficient, or five, back into the staging bank.

A biquad set is staged in the slot order b1, b2, a1, a2, b0. It is committed in a single clock edge, and only on an edge where the filter flags a sample boundary. The filter therefore never computes with a mix of old and new terms. The filter reads the store through its own combinational read port.

The store is laid out as follows:

- Entries 0–39 hold eight channel biquads.
- Entries 40–44 and 45–49 hold the high-pass and low-pass sets.
- Entries 50–61 hold single scale and mix values.

The controller itself does not interpret this layout.

Top module: `coefUploadTop`

## Requirements
- R1: After reset every host-readable register, the staging bank and every store entry read as zero.
- R2: Host map:
  - Offsets 0x00–0x0E are staging bytes. Coefficient slot k occupies bytes 3k (bits 23:16), 3k+1 and 3k+2 (bits 7:0).
  - 0x10 is the 6-bit coefficient address.
  - 0x11 is the command register.
  - 0x12 is status, with bit 0 busy and bit 1 error.
  - Any other offset reads zero.
  - All reads return the current flop contents.
- R3: Command bit 0 copies staging slot 0 into the store entry at the address. The new value is visible on the filter port one clock after the clock that accepted the command write.
- R4: Command bit 1 copies slots 0–4 into entries address to address+4. All five change on the same clock edge, which is the first edge after the command write at which sampleTick is high. Before that edge the store is unchanged.
- R5: Command bit 2 loads staging bytes 0–2 from the store entry at the address. Bytes 3–14 are left unchanged.
- R6: Command bit 3 loads all 15 staging bytes from entries address to address+4, in slot order.
- R7: Command behaviour:
  - Busy reads 1 while a command is pending.
  - Command bits 3:0 read back zero once the transfer ends.
  - Bits 7:4 of the command register keep the value last written, including through the self-clear.
- R8: When a command write sets several of bits 3:0, only the lowest-numbered set bit is kept, and the others are dropped.
- R9: A five-coefficient command (bit 1 or 3) whose address exceeds 59 changes neither the store nor the staging bank. It sets the error flag and clears one clock after acceptance. The error flag clears when a later command completes normally.
- R10: While busy, host writes to the staging bank, the address register and the command register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Host write strobe |
| regWrAddr | input | 5 | Host write offset |
| regWrData | input | 8 | Host write byte |
| regRdAddr | input | 5 | Host read offset |
| regRdData | output | 8 | Host read byte, combinational |
| sampleTick | input | 1 | Filter sample boundary, one cycle pulse or level |
| filtAddr | input | 6 | Filter read address |
| filtData | output | 24 | Coefficient at filtAddr |

## Verification
The bound checker watches several properties on every cycle:
- At most one command bit is ever pending.
- A set commit never happens on a cycle without sampleTick.
- Single and fetch commands finish in one cycle.
- An out-of-range set command always ends in the error state.
- The address and reserved bits stay frozen while busy.

Some behaviour can only be shown by the bench scenarios, using the cycle model:
- The byte ordering within slots.
- The actual values that land in the store or in staging.
- That all five entries of a set switch together on the tick edge.
- That writes during a pending set commit leave no trace.
- The boundary between address 59 and 60.

// File: rtl/coefUpPkg.sv
package coefUpPkg;

  // strobes from the sequencer to the register bank, one cycle each
  typedef struct packed {
    logic wrOne;     // commit slot 0 to the store
    logic wrFive;    // commit slots 0..4 to the store
    logic rdOne;     // fetch one entry into slot 0
    logic rdFive;    // fetch five entries into slots 0..4
    logic finish;    // clear the pending command bits
    logic flagErr;   // set the error flag
    logic clearErr;  // clear the error flag
  } seqStrobe_t;

  localparam int CMD_BITS = 4;

endpackage

// File: rtl/coefSeqCtrl.sv
module coefSeqCtrl
  import coefUpPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SET_N = 5,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic [CMD_BITS-1:0] cmdBits,
  input  logic [ADDR_W-1:0]   coefAddr,
  input  logic                sampleTick,
  output seqStrobe_t          strobe
);

  localparam int LAST_SET = DEPTH - SET_N;

  logic setInRange;

  assign setInRange = (int'(coefAddr) <= LAST_SET);

  always_comb begin
    strobe = '0;
    unique case (1'b1)
      cmdBits[0]: begin
        strobe.wrOne    = 1'b1;
        strobe.finish   = 1'b1;
        strobe.clearErr = 1'b1;
      end
      cmdBits[1]: begin
        if (!setInRange) begin
          strobe.flagErr = 1'b1;
          strobe.finish  = 1'b1;
        end else if (sampleTick) begin
          strobe.wrFive   = 1'b1;
          strobe.finish   = 1'b1;
          strobe.clearErr = 1'b1;
        end
      end
      cmdBits[2]: begin
        strobe.rdOne    = 1'b1;
        strobe.finish   = 1'b1;
        strobe.clearErr = 1'b1;
      end
      cmdBits[3]: begin
        if (!setInRange) begin
          strobe.flagErr = 1'b1;
          strobe.finish  = 1'b1;
        end else begin
          strobe.rdFive   = 1'b1;
          strobe.finish   = 1'b1;
          strobe.clearErr = 1'b1;
        end
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/coefRegBank.sv
module coefRegBank
  import coefUpPkg::*;
#(
  parameter int COEF_W  = 24,
  parameter int DEPTH   = 64,
  parameter int SET_N   = 5,
  parameter int HADDR_W = 5,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [HADDR_W-1:0]  wrAddr,
  input  logic [7:0]          wrData,
  input  logic [HADDR_W-1:0]  rdAddr,
  output logic [7:0]          rdData,
  input  logic [ADDR_W-1:0]   filtAddr,
  output logic [COEF_W-1:0]   filtData,
  input  seqStrobe_t          strobe,
  output logic [CMD_BITS-1:0] cmdBits,
  output logic [3:0]          cmdRsvd,
  output logic [ADDR_W-1:0]   coefAddr,
  output logic                errFlag
);

  localparam int BYTES    = COEF_W / 8;
  localparam int STAGE_N  = SET_N * BYTES;
  localparam logic [HADDR_W-1:0] OFS_ADDR = HADDR_W'(16);
  localparam logic [HADDR_W-1:0] OFS_CMD  = HADDR_W'(17);
  localparam logic [HADDR_W-1:0] OFS_STAT = HADDR_W'(18);

  logic [7:0]        stage    [STAGE_N];
  logic [COEF_W-1:0] store    [DEPTH];
  logic [COEF_W-1:0] slotWord [SET_N];
  logic [COEF_W-1:0] fetchWord[SET_N];
  logic [COEF_W-1:0] storeNew [DEPTH];
  logic              storeWe  [DEPTH];
  logic              busy;
  logic              hostWr;
  logic [CMD_BITS-1:0] cmdPick;

  assign busy   = |cmdBits;
  assign hostWr = wrEn && !busy;
  // keep only the lowest set command bit of the written byte
  assign cmdPick = wrData[CMD_BITS-1:0] & (~wrData[CMD_BITS-1:0] + CMD_BITS'(1));

  // assemble slot words (MSB byte first) and fetch words from the store
  always_comb begin
    for (int k = 0; k < SET_N; k++) begin
      for (int b = 0; b < BYTES; b++) begin
        slotWord[k][COEF_W-1-8*b -: 8] = stage[k*BYTES + b];
      end
      fetchWord[k] = store[coefAddr + ADDR_W'(k)];
    end
  end

  // per-entry write enables for single and set commits
  always_comb begin
    logic [ADDR_W-1:0] off;
    for (int i = 0; i < DEPTH; i++) begin
      off         = ADDR_W'(i) - coefAddr;
      storeWe[i]  = strobe.wrOne && (off == '0);
      storeNew[i] = slotWord[0];
      if (strobe.wrFive) begin
        for (int k = 0; k < SET_N; k++) begin
          if (off == ADDR_W'(k)) begin
            storeWe[i]  = 1'b1;
            storeNew[i] = slotWord[k];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (storeWe[i]) store[i] <= storeNew[i];
      end
    end
  end

  // staging bank: host writes when idle, fetches from the sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < STAGE_N; j++) stage[j] <= '0;
    end else begin
      for (int j = 0; j < STAGE_N; j++) begin
        if (hostWr && wrAddr == HADDR_W'(j)) begin
          stage[j] <= wrData;
        end else if (strobe.rdFive || (strobe.rdOne && (j < BYTES))) begin
          stage[j] <= fetchWord[j / BYTES][COEF_W-1-8*(j % BYTES) -: 8];
        end
      end
    end
  end

  // address, command, reserved and error registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coefAddr <= '0;
      cmdBits  <= '0;
      cmdRsvd  <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (hostWr && wrAddr == OFS_ADDR) coefAddr <= wrData[ADDR_W-1:0];
      if (hostWr && wrAddr == OFS_CMD) begin
        cmdBits <= cmdPick;
        cmdRsvd <= wrData[7:4];
      end else if (strobe.finish) begin
        cmdBits <= '0;
      end
      if (strobe.flagErr)       errFlag <= 1'b1;
      else if (strobe.clearErr) errFlag <= 1'b0;
    end
  end

  // live read mux
  always_comb begin
    rdData = '0;
    for (int j = 0; j < STAGE_N; j++) begin
      if (rdAddr == HADDR_W'(j)) rdData = stage[j];
    end
    if (rdAddr == OFS_ADDR) rdData = 8'(coefAddr);
    if (rdAddr == OFS_CMD)  rdData = {cmdRsvd, cmdBits};
    if (rdAddr == OFS_STAT) rdData = {6'b0, errFlag, busy};
  end

  assign filtData = store[filtAddr];

endmodule

// File: rtl/coefUploadTop.sv
module coefUploadTop
  import coefUpPkg::*;
#(
  parameter int COEF_W  = 24,
  parameter int DEPTH   = 64,
  parameter int SET_N   = 5,
  parameter int HADDR_W = 5,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [HADDR_W-1:0] regWrAddr,
  input  logic [7:0]         regWrData,
  input  logic [HADDR_W-1:0] regRdAddr,
  output logic [7:0]         regRdData,
  input  logic               sampleTick,
  input  logic [ADDR_W-1:0]  filtAddr,
  output logic [COEF_W-1:0]  filtData
);

  seqStrobe_t          seqStb;
  logic [CMD_BITS-1:0] cmdBits;
  logic [3:0]          cmdRsvd;
  logic [ADDR_W-1:0]   coefAddr;
  logic                errFlag;

  coefSeqCtrl #(.DEPTH(DEPTH), .SET_N(SET_N)) uCtrl (
    .cmdBits   (cmdBits),
    .coefAddr  (coefAddr),
    .sampleTick(sampleTick),
    .strobe    (seqStb)
  );

  coefRegBank #(.COEF_W(COEF_W), .DEPTH(DEPTH), .SET_N(SET_N), .HADDR_W(HADDR_W)) uBank (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (regWrEn),
    .wrAddr  (regWrAddr),
    .wrData  (regWrData),
    .rdAddr  (regRdAddr),
    .rdData  (regRdData),
    .filtAddr(filtAddr),
    .filtData(filtData),
    .strobe  (seqStb),
    .cmdBits (cmdBits),
    .cmdRsvd (cmdRsvd),
    .coefAddr(coefAddr),
    .errFlag (errFlag)
  );

endmodule

// File: rtl/coefUploadChk.sv
module coefUploadChk #(
  parameter int DEPTH = 64,
  parameter int SET_N = 5,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleTick,
  input logic              wrFive,
  input logic [3:0]        cmdBits,
  input logic [3:0]        cmdRsvd,
  input logic [ADDR_W-1:0] coefAddr,
  input logic              errFlag
);

  localparam int LAST_SET = DEPTH - SET_N;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdBits)); // R8

  AST_SET_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    wrFive |-> sampleTick); // R4

  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits[0] || cmdBits[2] || cmdBits[3]) |=> (cmdBits == 4'b0)); // R7

  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    ((cmdBits[1] || cmdBits[3]) && (int'(coefAddr) > LAST_SET))
      |=> (errFlag && cmdBits == 4'b0)); // R9

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits != 4'b0) |=> $stable(coefAddr)); // R10

  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits != 4'b0) |=> $stable(cmdRsvd)); // R7

endmodule

bind coefUploadTop coefUploadChk chk (
  .clk       (clk),
  .rstN      (rstN),
  .sampleTick(sampleTick),
  .wrFive    (seqStb.wrFive),
  .cmdBits   (cmdBits),
  .cmdRsvd   (cmdRsvd),
  .coefAddr  (coefAddr),
  .errFlag   (errFlag)
);

// File: tb/tb_coefUploadTop.sv
`timescale 1ns/1ps
module tb_coefUploadTop;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [4:0] regWrAddr = '0;
  logic [7:0] regWrData = '0;
  logic [4:0] regRdAddr = '0;
  logic [7:0] regRdData;
  logic       sampleTick = 1'b0;
  logic [5:0] filtAddr = '0;
  logic [23:0] filtData;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  coefUploadTop dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .sampleTick(sampleTick), .filtAddr(filtAddr), .filtData(filtData)
  );

  // ---------------- behavioural reference model ----------------
  int mRam[64];
  int mStage[15];
  int mAddr = 0, mCmd = 0, mRsvd = 0, mErr = 0;

  function automatic int slotVal(int k);
    return (mStage[3*k] << 16) | (mStage[3*k+1] << 8) | mStage[3*k+2];
  endfunction

  function automatic void loadSlot(int k, int v);
    mStage[3*k]   = (v >> 16) & 255;
    mStage[3*k+1] = (v >> 8) & 255;
    mStage[3*k+2] = v & 255;
  endfunction

  initial begin
    foreach (mRam[i]) mRam[i] = 0;
    foreach (mStage[i]) mStage[i] = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mRam[i]) mRam[i] = 0;
      foreach (mStage[i]) mStage[i] = 0;
      mAddr = 0; mCmd = 0; mRsvd = 0; mErr = 0;
    end else if (mCmd != 0) begin
      if (mCmd == 1) begin
        mRam[mAddr] = slotVal(0); mCmd = 0; mErr = 0;
      end else if (mCmd == 2) begin
        if (mAddr > 59) begin mErr = 1; mCmd = 0; end
        else if (sampleTick) begin
          for (int k = 0; k < 5; k++) mRam[mAddr+k] = slotVal(k);
          mCmd = 0; mErr = 0;
        end
      end else if (mCmd == 4) begin
        loadSlot(0, mRam[mAddr]); mCmd = 0; mErr = 0;
      end else begin
        if (mAddr > 59) begin mErr = 1; mCmd = 0; end
        else begin
          for (int k = 0; k < 5; k++) loadSlot(k, mRam[mAddr+k]);
          mCmd = 0; mErr = 0;
        end
      end
    end else if (regWrEn) begin
      if (regWrAddr < 15) mStage[regWrAddr] = regWrData;
      else if (regWrAddr == 16) mAddr = regWrData & 63;
      else if (regWrAddr == 17) begin
        if (regWrData[0]) mCmd = 1;
        else if (regWrData[1]) mCmd = 2;
        else if (regWrData[2]) mCmd = 4;
        else if (regWrData[3]) mCmd = 8;
        else mCmd = 0;
        mRsvd = regWrData >> 4;
      end
    end
  end

  function automatic int expRead(int a);
    if (a < 15) return mStage[a];
    if (a == 16) return mAddr;
    if (a == 17) return (mRsvd << 4) | mCmd;
    if (a == 18) return (mErr << 1) | (mCmd != 0 ? 1 : 0);
    return 0;
  endfunction

  function automatic string tagOf(int a);
    if (a == 17) return "R7";
    if (a == 18) return "R9";
    return "R2";
  endfunction

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      compared++;
      if (int'(regRdData) != expRead(int'(regRdAddr))) begin
        mismatched++;
        $display("FAIL %s model reg 0x%0h: actual 0x%0h expected 0x%0h",
                 tagOf(int'(regRdAddr)), regRdAddr, regRdData, expRead(int'(regRdAddr)));
      end
      compared++;
      if (int'(filtData) != mRam[filtAddr]) begin
        mismatched++;
        $display("FAIL R3 model filt[%0d]: actual 0x%0h expected 0x%0h",
                 filtAddr, filtData, mRam[filtAddr]);
      end
    end
  end

  // ---------------- directed helpers ----------------
  int sweep = 0;

  task automatic checkVal(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(int a, int d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = 5'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      regRdAddr = 5'(sweep % 19);
      filtAddr  = 6'((sweep * 7) % 64);
      sweep++;
    end
  endtask

  task automatic checkRd(string req, int a, int exp);
    @(negedge clk);
    regRdAddr = 5'(a); #1;
    checkVal(req, $sformatf("reg 0x%0h", a), int'(regRdData), exp);
  endtask

  task automatic checkRdNow(string req, int a, int exp);
    regRdAddr = 5'(a); #1;
    checkVal(req, $sformatf("reg 0x%0h", a), int'(regRdData), exp);
  endtask

  task automatic checkFilt(string req, int a, int exp);
    @(negedge clk);
    filtAddr = 6'(a); #1;
    checkVal(req, $sformatf("filt[%0d]", a), int'(filtData), exp);
  endtask

  task automatic loadSet();
    int bytesV[15] = '{8'h80, 8'h00, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'hFF,
                       8'hFF, 8'h00, 8'h01, 8'h00, 8'hC0, 8'h00, 8'h00};
    for (int j = 0; j < 15; j++) hostWrite(j, bytesV[j]);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkRd("R1", 18, 0);
    checkRd("R1", 0, 0);
    checkRd("R1", 17, 0);
    checkFilt("R1", 5, 0);

    // R3 single commit
    hostWrite(0, 8'h12); hostWrite(1, 8'h34); hostWrite(2, 8'h56);
    hostWrite(16, 7);
    hostWrite(17, 8'h01);
    checkRdNow("R7", 18, 1);
    idle(2);
    checkFilt("R3", 7, 24'h123456);
    checkRd("R7", 17, 0);

    // R4 set commit waits for the tick; R10 writes ignored while busy
    loadSet();
    hostWrite(16, 40);
    hostWrite(17, 8'h02);
    checkRdNow("R7", 18, 1);
    idle(5);
    checkFilt("R4", 40, 0);
    checkFilt("R4", 44, 0);
    hostWrite(16, 3);
    hostWrite(0, 8'hAA);
    hostWrite(17, 8'h04);
    checkRd("R10", 16, 40);
    checkRd("R10", 0, 8'h80);
    checkRd("R10", 17, 8'h02);
    @(negedge clk);
    sampleTick = 1'b1; filtAddr = 44; #1;
    checkVal("R4", "filt[44] before tick edge", int'(filtData), 0);
    @(negedge clk);
    sampleTick = 1'b0;
    checkFilt("R4", 40, 24'h800001);
    checkFilt("R4", 41, 24'hFFFFFF);
    checkFilt("R4", 42, 24'h7FFFFF);
    checkFilt("R4", 43, 24'h000100);
    checkFilt("R4", 44, 24'hC00000);
    checkRd("R7", 18, 0);

    // R9 boundary: 59 accepted
    sampleTick = 1'b1;
    hostWrite(16, 59);
    hostWrite(17, 8'h02);
    idle(2);
    checkFilt("R9", 59, 24'h800001);
    checkFilt("R9", 63, 24'hC00000);
    checkRd("R9", 18, 0);

    // R9 address 60 rejected for write-set and read-set
    hostWrite(3, 8'h11); hostWrite(4, 8'h22); hostWrite(5, 8'h33);
    hostWrite(16, 60);
    hostWrite(17, 8'h02);
    idle(2);
    checkRd("R9", 18, 2);
    checkFilt("R9", 60, 24'hFFFFFF);
    hostWrite(17, 8'h08);
    idle(2);
    checkRd("R9", 3, 8'h11);
    checkRd("R9", 18, 2);
    hostWrite(17, 8'h01);
    idle(2);
    checkRd("R9", 18, 0);
    checkFilt("R3", 60, 24'h800001);
    sampleTick = 1'b0;

    // R8 priority with R5 single fetch and R7 reserved bits
    hostWrite(0, 0); hostWrite(1, 0); hostWrite(2, 0);
    hostWrite(16, 7);
    hostWrite(17, 8'hAC);
    idle(2);
    checkRd("R5", 0, 8'h12);
    checkRd("R5", 2, 8'h56);
    checkRd("R8", 3, 8'h11);
    checkRd("R7", 17, 8'hA0);

    // R6 five fetch
    hostWrite(16, 40);
    hostWrite(17, 8'h08);
    idle(2);
    checkRd("R6", 0, 8'h80);
    checkRd("R6", 3, 8'hFF);
    checkRd("R6", 6, 8'h7F);
    checkRd("R6", 10, 8'h01);
    checkRd("R6", 12, 8'hC0);
    checkRd("R6", 14, 8'h00);
    checkRd("R7", 17, 8'h00);

    // R8 bits 0 and 1 together: single commit, no tick needed
    hostWrite(16, 45);
    hostWrite(17, 8'h03);
    idle(2);
    checkFilt("R8", 45, 24'h800001);
    checkFilt("R8", 46, 0);
    checkRd("R7", 18, 0);

    // R2 unmapped offsets
    checkRd("R2", 31, 0);
    checkRd("R2", 19, 0);
    checkRd("R2", 16, 45);

    idle(20);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule